// File: doc/BRIEF.md
# Pipelined Quadrature Sine/Cosine Generator

This block turns a per-sample phase step into a stream of signed sine and cosine samples. A 32-bit phase register advances by a registered copy of the step on every enabled cycle and wraps freely. The top twelve bits of that phase select one of 4096 points on the unit circle. Because the stored table spans only a quarter of a period, the four quadrants are rebuilt from it by mirroring and sign changes. The path is split into four register stages so that it can be clocked at a high sample rate.

Small frequency-resolution spurs can be spread by switching on a pseudo-random dither, which adds a few low bits of a free-running shift register to the phase step. The caller holds `enable` high on each cycle that should produce a sample. The matching sample appears at the outputs, flagged by `valid_out`, four clock edges later.

Top module: `nco_quad_top`

## Requirements
- R1: The phase register is 32 bits wide, starts at 0 after reset, wraps modulo 2^32, and on every edge where `enable` is 1 adds the registered step. With dither off and a constant `phase_inc` P applied at least two edges before the first enable, the n-th valid sample (n = 1, 2, ...) has phase n*P mod 2^32.
- R2: The step used by the accumulator is a register loaded on every edge, enabled or not, from `phase_inc`. A change of `phase_inc` therefore reaches the phase one edge later than a direct path would.
- R3: With p = phase[31:20], `sin_out` equals round(32767*sin(2*pi*(p+0.5)/4096)) within 1 LSB, and `cos_out` equals the same value evaluated at p+1024 (mod 4096).
- R4: The table holds a single quadrant of 1024 magnitudes, addressed by phase[29:20]. Phase[31:30] selects the quadrant: quadrants 1 and 3 read the mirrored address, and quadrants 2 and 3 negate the sine. Outputs are never -32768, and sin^2+cos^2 stays within 100000 of 32767^2.
- R5: `valid_out` equals the value `enable` had four edges earlier. No phase advance takes place on an edge where `enable` is 0.
- R6: On an edge that delivers no new sample (`valid_out` low afterwards), `sin_out` and `cos_out` keep their previous values.
- R7: The active-low reset `rst_n` is asynchronous. It clears the phase, the registered step, every pipeline stage and the outputs at once, so the outputs read 0 and `valid_out` reads 0. Samples in flight when reset arrives are discarded.
- R8: When `dither_en` is 1, the registered step is `phase_inc` plus the low 4 bits of a 16-bit right-shifting LFSR, using the feedback mask 0xB400 and a nonzero seed. The LFSR shifts every cycle, so the added value lies in 0..15 and is not constant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Produce a sample and advance phase this cycle |
| phase_inc | input | 32 | Phase step per enabled cycle (2^32 = one period) |
| dither_en | input | 1 | Add LFSR dither to the phase step |
| sin_out | output | 16 | Signed sine sample, two's complement |
| cos_out | output | 16 | Signed cosine sample, two's complement |
| valid_out | output | 1 | Sample on sin_out/cos_out is new this cycle |

## Verification
The assertions check on every cycle that the valid flag trails enable by exactly four edges and stays low right after reset. They also check that outputs hold whenever no sample is delivered, that -32768 never appears, and that every valid sample sits on the circle of radius 32767. The exact sample values per quadrant, the one-edge delay of a changed step, wrap-around of the phase, the bounded effect of dither, and the flushing of in-flight samples by a mid-stream reset all depend on the phase history. Only the bench's scenarios, driven against a reference model of the phase, can show those.

// File: rtl/nco_pkg.sv
package nco_pkg;

    localparam int PHASE_W     = 32;
    localparam int OUT_W       = 16;
    localparam int LUT_AW      = 10;
    localparam int LFSR_W      = 16;
    localparam int DITHER_W    = 4;
    localparam int AMPLITUDE   = 32767;
    localparam logic [LFSR_W-1:0] LFSR_MASK = 16'hB400;
    localparam logic [LFSR_W-1:0] LFSR_INIT = 16'hACE1;

    typedef enum logic [1:0] {
        QUAD_0 = 2'd0,
        QUAD_1 = 2'd1,
        QUAD_2 = 2'd2,
        QUAD_3 = 2'd3
    } quad_e;

    // Magnitude of one quarter-wave point, sampled at the centre of its
    // phase bin so that mirrored addresses give symmetric values.
    function automatic logic [OUT_W-1:0] quarter_point(input int idx,
                                                       input int depth,
                                                       input int amp);
        real angle;
        real value;
        angle = (3.14159265358979323846 / 2.0) * (real'(idx) + 0.5) / real'(depth);
        value = real'(amp) * $sin(angle);
        return OUT_W'($rtoi(value + 0.5));
    endfunction

endpackage

// File: rtl/nco_dither_lfsr.sv
module nco_dither_lfsr #(
    parameter int                 WIDTH    = nco_pkg::LFSR_W,
    parameter int                 OUT_BITS = nco_pkg::DITHER_W,
    parameter logic [WIDTH-1:0]   MASK     = nco_pkg::LFSR_MASK,
    parameter logic [WIDTH-1:0]   INIT     = nco_pkg::LFSR_INIT
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic [OUT_BITS-1:0] dither_o
);

    typedef struct packed {
        logic [WIDTH-1:0] shreg;
    } lfsr_st_t;

    lfsr_st_t st_d;
    lfsr_st_t st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.shreg[0]) begin
            st_d.shreg = (st_q.shreg >> 1) ^ MASK;
        end else begin
            st_d.shreg = st_q.shreg >> 1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.shreg <= INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign dither_o = st_q.shreg[OUT_BITS-1:0];

endmodule

// File: rtl/nco_phase_stage.sv
module nco_phase_stage #(
    parameter int PHASE_W  = nco_pkg::PHASE_W,
    parameter int DITHER_W = nco_pkg::DITHER_W,
    parameter int TOP_W    = nco_pkg::LUT_AW + 2,
    localparam int PAD_W   = PHASE_W - DITHER_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable_i,
    input  logic [PHASE_W-1:0]  phase_inc_i,
    input  logic                dither_en_i,
    input  logic [DITHER_W-1:0] dither_i,
    output logic [TOP_W-1:0]    phase_top_o,
    output logic                vld_o
);

    typedef struct packed {
        logic [PHASE_W-1:0] step;
        logic [PHASE_W-1:0] acc;
        logic               vld;
    } phase_st_t;

    phase_st_t st_d;
    phase_st_t st_q;

    logic [PHASE_W-1:0] dither_ext;

    always_comb begin
        dither_ext = dither_en_i ? {{PAD_W{1'b0}}, dither_i} : '0;
        st_d       = st_q;
        // step register: loaded every cycle, cuts the add chain
        st_d.step  = phase_inc_i + dither_ext;
        st_d.vld   = enable_i;
        if (enable_i) begin
            st_d.acc = st_q.acc + st_q.step;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_top_o = st_q.acc[PHASE_W-1 -: TOP_W];
    assign vld_o       = st_q.vld;

endmodule

// File: rtl/nco_quarter_lut.sv
module nco_quarter_lut #(
    parameter int  LUT_AW = nco_pkg::LUT_AW,
    parameter int  OUT_W  = nco_pkg::OUT_W,
    parameter int  AMP    = nco_pkg::AMPLITUDE,
    localparam int DEPTH  = 1 << LUT_AW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LUT_AW+1:0]   phase_top_i,
    input  logic                vld_i,
    output logic [OUT_W-1:0]    fwd_o,
    output logic [OUT_W-1:0]    mir_o,
    output nco_pkg::quad_e      quad_o,
    output logic                vld_o
);

    typedef struct packed {
        logic [OUT_W-1:0] fwd;
        logic [OUT_W-1:0] mir;
        nco_pkg::quad_e   quad;
        logic             vld;
    } lut_st_t;

    lut_st_t st_d;
    lut_st_t st_q;

    logic [OUT_W-1:0]  table_w [DEPTH];
    logic [LUT_AW-1:0] addr_fwd;
    logic [LUT_AW-1:0] addr_mir;

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_table
        localparam logic [OUT_W-1:0] POINT = nco_pkg::quarter_point(gi, DEPTH, AMP);
        assign table_w[gi] = POINT;
    end

    always_comb begin
        addr_fwd = phase_top_i[LUT_AW-1:0];
        addr_mir = ~phase_top_i[LUT_AW-1:0];
        st_d     = st_q;
        st_d.vld = vld_i;
        if (vld_i) begin
            st_d.fwd  = table_w[addr_fwd];
            st_d.mir  = table_w[addr_mir];
            st_d.quad = nco_pkg::quad_e'(phase_top_i[LUT_AW+1:LUT_AW]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fwd_o  = st_q.fwd;
    assign mir_o  = st_q.mir;
    assign quad_o = st_q.quad;
    assign vld_o  = st_q.vld;

endmodule

// File: rtl/nco_quadrant_out.sv
module nco_quadrant_out #(
    parameter int OUT_W = nco_pkg::OUT_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [OUT_W-1:0]        fwd_i,
    input  logic [OUT_W-1:0]        mir_i,
    input  nco_pkg::quad_e          quad_i,
    input  logic                    vld_i,
    output logic signed [OUT_W-1:0] sin_o,
    output logic signed [OUT_W-1:0] cos_o,
    output logic                    vld_o
);

    typedef struct packed {
        // negate stage
        logic signed [OUT_W-1:0] fwd_pos;
        logic signed [OUT_W-1:0] fwd_neg;
        logic signed [OUT_W-1:0] mir_pos;
        logic signed [OUT_W-1:0] mir_neg;
        nco_pkg::quad_e          quad;
        logic                    neg_vld;
        // select stage
        logic signed [OUT_W-1:0] sin_v;
        logic signed [OUT_W-1:0] cos_v;
        logic                    sel_vld;
    } out_st_t;

    out_st_t st_d;
    out_st_t st_q;

    always_comb begin
        st_d         = st_q;
        st_d.neg_vld = vld_i;
        if (vld_i) begin
            st_d.fwd_pos = fwd_i;
            st_d.fwd_neg = -fwd_i;
            st_d.mir_pos = mir_i;
            st_d.mir_neg = -mir_i;
            st_d.quad    = quad_i;
        end
        st_d.sel_vld = st_q.neg_vld;
        if (st_q.neg_vld) begin
            unique case (st_q.quad)
                nco_pkg::QUAD_0: begin
                    st_d.sin_v = st_q.fwd_pos;
                    st_d.cos_v = st_q.mir_pos;
                end
                nco_pkg::QUAD_1: begin
                    st_d.sin_v = st_q.mir_pos;
                    st_d.cos_v = st_q.fwd_neg;
                end
                nco_pkg::QUAD_2: begin
                    st_d.sin_v = st_q.fwd_neg;
                    st_d.cos_v = st_q.mir_neg;
                end
                default: begin
                    st_d.sin_v = st_q.mir_neg;
                    st_d.cos_v = st_q.fwd_pos;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sin_o = st_q.sin_v;
    assign cos_o = st_q.cos_v;
    assign vld_o = st_q.sel_vld;

endmodule

// File: rtl/nco_quad_top.sv
module nco_quad_top #(
    parameter int  PHASE_W  = nco_pkg::PHASE_W,
    parameter int  OUT_W    = nco_pkg::OUT_W,
    parameter int  LUT_AW   = nco_pkg::LUT_AW,
    parameter int  DITHER_W = nco_pkg::DITHER_W,
    parameter int  AMP      = nco_pkg::AMPLITUDE,
    localparam int TOP_W    = LUT_AW + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    enable,
    input  logic [PHASE_W-1:0]      phase_inc,
    input  logic                    dither_en,
    output logic signed [OUT_W-1:0] sin_out,
    output logic signed [OUT_W-1:0] cos_out,
    output logic                    valid_out
);

    logic [DITHER_W-1:0] dither_w;
    logic [TOP_W-1:0]    phase_top_w;
    logic                acc_vld_w;
    logic [OUT_W-1:0]    fwd_w;
    logic [OUT_W-1:0]    mir_w;
    nco_pkg::quad_e      quad_w;
    logic                lut_vld_w;

    nco_dither_lfsr #(
        .OUT_BITS (DITHER_W)
    ) u_dither (
        .clk      (clk),
        .rst_n    (rst_n),
        .dither_o (dither_w)
    );

    nco_phase_stage #(
        .PHASE_W  (PHASE_W),
        .DITHER_W (DITHER_W),
        .TOP_W    (TOP_W)
    ) u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable_i    (enable),
        .phase_inc_i (phase_inc),
        .dither_en_i (dither_en),
        .dither_i    (dither_w),
        .phase_top_o (phase_top_w),
        .vld_o       (acc_vld_w)
    );

    nco_quarter_lut #(
        .LUT_AW (LUT_AW),
        .OUT_W  (OUT_W),
        .AMP    (AMP)
    ) u_lut (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase_top_i (phase_top_w),
        .vld_i       (acc_vld_w),
        .fwd_o       (fwd_w),
        .mir_o       (mir_w),
        .quad_o      (quad_w),
        .vld_o       (lut_vld_w)
    );

    nco_quadrant_out #(
        .OUT_W (OUT_W)
    ) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .fwd_i  (fwd_w),
        .mir_i  (mir_w),
        .quad_i (quad_w),
        .vld_i  (lut_vld_w),
        .sin_o  (sin_out),
        .cos_o  (cos_out),
        .vld_o  (valid_out)
    );

endmodule

// File: rtl/nco_quad_checker.sv
module nco_quad_checker #(
    parameter int OUT_W = nco_pkg::OUT_W,
    parameter int AMP   = nco_pkg::AMPLITUDE
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    enable,
    input logic                    valid_out,
    input logic signed [OUT_W-1:0] sin_out,
    input logic signed [OUT_W-1:0] cos_out
);

    localparam logic signed [OUT_W-1:0] MOST_NEG = {1'b1, {(OUT_W-1){1'b0}}};
    localparam longint RADIUS_SQ = longint'(AMP) * longint'(AMP);
    localparam longint NORM_TOL  = 100000;

    logic [2:0] since_rst_q;
    longint     norm_err;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst_q <= '0;
        end else if (since_rst_q != 3'd4) begin
            since_rst_q <= since_rst_q + 3'd1;
        end
    end

    always_comb begin
        norm_err = longint'(sin_out) * longint'(sin_out)
                 + longint'(cos_out) * longint'(cos_out) - RADIUS_SQ;
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q == 3'd4) |-> (valid_out == $past(enable, 4))); // R5

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q != 3'd4) |-> !valid_out); // R7

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_out |-> ($stable(sin_out) && $stable(cos_out))); // R6

    AST_NO_MOST_NEGATIVE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |-> ((sin_out != MOST_NEG) && (cos_out != MOST_NEG))); // R4

    AST_ON_CIRCLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |-> ((norm_err <= NORM_TOL) && (norm_err >= -NORM_TOL))); // R4

endmodule

bind nco_quad_top nco_quad_checker #(
    .OUT_W (OUT_W),
    .AMP   (AMP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .valid_out (valid_out),
    .sin_out   (sin_out),
    .cos_out   (cos_out)
);

// File: tb/nco_quad_top_tb_top.sv
module nco_quad_top_tb_top;

    localparam int  CLK_PERIOD = 10;
    localparam real PI_R       = 3.14159265358979323846;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               enable = 1'b0;
    logic [31:0]        phase_inc = '0;
    logic               dither_en = 1'b0;
    logic signed [15:0] sin_out;
    logic signed [15:0] cos_out;
    logic               valid_out;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    done     = 1'b0;
    bit    model_on = 1'b1;
    string cur_req  = "R1";

    // reference phase model, evaluated at each falling edge
    int          cyc = 0;
    logic [31:0] acc_m = '0;
    logic [31:0] step_m = '0;
    int          due_q[$];
    logic [31:0] ph_q[$];
    logic signed [15:0] prev_sin = '0;
    logic signed [15:0] prev_cos = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nco_quad_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .phase_inc (phase_inc),
        .dither_en (dither_en),
        .sin_out   (sin_out),
        .cos_out   (cos_out),
        .valid_out (valid_out)
    );

    function automatic int ideal(input int p);
        real v;
        v = 32767.0 * $sin(2.0 * PI_R * (real'(p) + 0.5) / 4096.0);
        if (v >= 0.0) return $rtoi(v + 0.5);
        return -$rtoi(-v + 0.5);
    endfunction

    function automatic bit near(input logic signed [15:0] got, input int want);
        int d;
        d = int'(got) - want;
        return (d <= 1) && (d >= -1);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            acc_m  = '0;
            step_m = '0;
            due_q.delete();
            ph_q.delete();
            prev_sin = '0;
            prev_cos = '0;
        end else begin
            if (!valid_out) begin
                check(sin_out == prev_sin && cos_out == prev_cos, "R6",
                      "output held while idle", int'(sin_out), int'(prev_sin));
            end
            if (model_on) begin
                if (valid_out) begin
                    if (due_q.size() == 0) begin
                        check(1'b0, "R5", "valid without enable", 1, 0);
                    end else begin
                        int          due;
                        logic [31:0] ph;
                        int          p;
                        due = due_q.pop_front();
                        ph  = ph_q.pop_front();
                        p   = int'(ph[31:20]);
                        check(due == cyc, "R5", "valid latency cycle", cyc, due);
                        check(near(sin_out, ideal(p)), cur_req, "sine sample",
                              int'(sin_out), ideal(p));
                        check(near(cos_out, ideal((p + 1024) % 4096)), cur_req, "cosine sample",
                              int'(cos_out), ideal((p + 1024) % 4096));
                    end
                end else if (due_q.size() != 0 && due_q[0] == cyc) begin
                    check(1'b0, "R5", "missing valid", 0, 1);
                    void'(due_q.pop_front());
                    void'(ph_q.pop_front());
                end
                // model the coming rising edge
                if (enable) begin
                    acc_m = acc_m + step_m;
                    due_q.push_back(cyc + 4);
                    ph_q.push_back(acc_m);
                end
                step_m = phase_inc;
            end
            prev_sin = sin_out;
            prev_cos = cos_out;
        end
    end

    task automatic drive_edge();
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive_edge();
    endtask

    task automatic apply_reset();
        drive_edge();
        rst_n  = 1'b0;
        enable = 1'b0;
        #1;
        check(valid_out == 1'b0, "R7", "valid cleared by reset", int'(valid_out), 0);
        check(sin_out == 0 && cos_out == 0, "R7", "outputs cleared by reset",
              int'(sin_out), 0);
        idle(3);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        cur_req = "R7";
        check(valid_out == 1'b0, "R7", "valid low in reset", int'(valid_out), 0);
        check(sin_out == 0, "R7", "sine zero in reset", int'(sin_out), 0);
        check(cos_out == 0, "R7", "cosine zero in reset", int'(cos_out), 0);
        idle(2);
        rst_n = 1'b1;
        idle(6);
        check(valid_out == 1'b0, "R7", "no sample without enable", int'(valid_out), 0);
    endtask

    task automatic run_tone(input logic [31:0] step, input int n);
        phase_inc = step;
        idle(3);
        enable = 1'b1;
        idle(n);
        enable = 1'b0;
        idle(6);
    endtask

    task automatic t_steady_tones();
        cur_req = "R1";
        apply_reset();
        run_tone(32'h0123_4567, 200);
        apply_reset();
        run_tone(32'hC000_0001, 40);   // wraps every few samples
        apply_reset();
        run_tone(32'h000F_FFF8, 60);   // just under one table step, no dither
    endtask

    task automatic t_quadrant_sweep();
        cur_req = "R4";
        apply_reset();
        run_tone(32'h0010_0000, 4100); // every table point in every quadrant
        cur_req = "R3";
        apply_reset();
        run_tone(32'h3FF0_0000, 64);   // lands next to quadrant boundaries
    endtask

    task automatic t_step_change();
        cur_req = "R2";
        apply_reset();
        phase_inc = 32'h0200_0000;
        idle(3);
        enable = 1'b1;
        for (int i = 0; i < 40; i++) begin
            drive_edge();
            if (i % 3 == 0) phase_inc = phase_inc * 32'd3 + 32'h0145_0000;
        end
        enable = 1'b0;
        phase_inc = 32'h7000_0000;     // changes while idle: no advance
        idle(4);
        enable = 1'b1;
        idle(5);
        enable = 1'b0;
        idle(6);
    endtask

    task automatic t_gapped_enable();
        logic [15:0] pattern;
        cur_req = "R5";
        pattern = 16'b1011_0010_1110_0101;
        apply_reset();
        phase_inc = 32'h0733_0000;
        idle(3);
        for (int i = 0; i < 64; i++) begin
            enable = pattern[i % 16];
            drive_edge();
        end
        enable = 1'b0;
        idle(6);
    endtask

    task automatic t_hold_idle();
        logic signed [15:0] s0;
        logic signed [15:0] c0;
        cur_req = "R6";
        apply_reset();
        phase_inc = 32'h0511_0000;
        idle(3);
        enable = 1'b1;
        idle(10);
        enable = 1'b0;
        idle(6);
        s0 = sin_out;
        c0 = cos_out;
        idle(20);
        check(sin_out == s0, "R6", "sine held over long idle", int'(sin_out), int'(s0));
        check(cos_out == c0, "R6", "cosine held over long idle", int'(cos_out), int'(c0));
    endtask

    task automatic t_reset_midstream();
        cur_req = "R7";
        apply_reset();
        phase_inc = 32'h0A00_0000;
        idle(3);
        enable = 1'b1;
        idle(30);
        rst_n = 1'b0;                  // enable stays high
        #1;
        check(valid_out == 1'b0, "R7", "valid dropped mid-stream", int'(valid_out), 0);
        check(sin_out == 0 && cos_out == 0, "R7", "outputs cleared mid-stream",
              int'(sin_out), 0);
        idle(2);
        rst_n = 1'b1;                  // restarts from phase 0 with step 0 first
        idle(20);
        enable = 1'b0;
        idle(6);
    endtask

    task automatic t_dither();
        int hits;
        int n;
        cur_req = "R8";
        model_on = 1'b0;
        apply_reset();
        dither_en = 1'b1;
        phase_inc = 32'h000F_FFF8;
        idle(3);
        enable = 1'b1;
        hits = 0;
        n = 0;
        while (n < 64) begin
            @(negedge clk);
            if (valid_out) begin
                n++;
                check(near(sin_out, ideal(n - 1)) || near(sin_out, ideal(n)), "R8",
                      "dithered sample within one bin", int'(sin_out), ideal(n - 1));
                if (near(sin_out, ideal(n)) && !near(sin_out, ideal(n - 1))) hits++;
            end
        end
        drive_edge();
        enable = 1'b0;
        idle(6);
        check(hits > 0, "R8", "dither pushed phase past one bin", hits, 1);
        dither_en = 1'b0;
        model_on = 1'b1;
        apply_reset();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_steady_tones();
        t_quadrant_sweep();
        t_step_change();
        t_gapped_enable();
        t_hold_idle();
        t_reset_midstream();
        t_dither();
        idle(4);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule